// File: doc/BRIEF.md
# Parallel Video to Stream Input Bridge

This block takes pixels from a native parallel video source and turns them into a video stream with a valid/ready handshake. The native side presents one pixel per clock with a data-valid qualifier, a vertical sync, a horizontal sync and an interlace field bit. The stream side carries the pixel, a start-of-frame marker on the user sideband, an end-of-line marker on tlast and the field bit. All of these belong to the beat being transferred.

Both sides share a single clock. A synchronous FIFO sits between them and absorbs short stalls from the downstream consumer. A video source cannot be paused, so a pixel that arrives while the FIFO is full is discarded and a sticky overflow flag is raised. Each stored entry keeps the pixel, the start-of-frame bit, the end-of-line bit and the field bit together. The sideband therefore always matches its own pixel.

After any reset the bridge ignores pixels until it has seen a vertical sync, so the stream always starts on a frame boundary. A reset also empties the FIFO.

Top module: `vid2axis_bridge`

## Requirements
- R1: While reset (rst_n low) is applied and in the cycle after it, m_tvalid and ovf_flag are 0.
- R2: After reset, no pixel is accepted until vid_vsync has been high for at least one cycle. Pixels presented earlier never appear on the stream.
- R3: m_tuser is 1 on the first accepted pixel after each vid_vsync pulse, and 0 on every other beat.
- R4: m_tlast is 1 on an accepted pixel when the next cycle accepts no pixel, which is the end of the active run. It is 0 otherwise.
- R5: m_field on every beat equals the vid_field value sampled together with that beat's pixel.
- R6: Accepted pixels leave in arrival order with unchanged data. While m_tvalid is 1 and m_tready is 0, the beat and its sideband stay stable.
- R7: An accepted pixel that finds the FIFO full (FIFO_DEPTH entries) is dropped, and ovf_flag rises one cycle later. ovf_flag then stays at 1 until reset.
- R8: Asserting rst_n low discards every buffered pixel, and a new vid_vsync is needed before pixels are accepted again.
- R9: A cycle with vid_de high while vid_hsync or vid_vsync is high is blanking. No pixel is accepted in that cycle, and it ends any active run.
- R10: If a pixel is accepted while the FIFO is empty, m_tvalid rises after the second rising clock edge following the cycle in which the pixel was presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for both sides |
| rst_n | input | 1 | Synchronous active-low reset; flushes the FIFO |
| vid_data | input | DATA_W | Native pixel value |
| vid_vsync | input | 1 | Vertical sync, active high |
| vid_hsync | input | 1 | Horizontal sync, active high |
| vid_de | input | 1 | Pixel data-valid qualifier |
| vid_field | input | 1 | Interlace field bit of the current pixel |
| m_tdata | output | DATA_W | Stream pixel |
| m_tvalid | output | 1 | Stream beat available |
| m_tready | input | 1 | Consumer accepts the beat |
| m_tuser | output | 1 | Start of frame |
| m_tlast | output | 1 | End of line |
| m_field | output | 1 | Field bit carried with the beat |
| ovf_flag | output | 1 | Sticky pixel-drop indicator |

## Verification
Every native input is driven just after a rising edge. A pixel accepted in a given cycle is registered at the next edge and written to the FIFO at the edge after that, so it is visible on the stream half a cycle later. The latency checks sample at exactly those two falling edges. End of line is only known one cycle after the last pixel, and the bench's expected-beat model marks the tail pixel at that point. This always happens before the beat can leave the FIFO. The overflow flag is checked a few idle cycles after the drop, and buffered data is checked before and after a reset pulse.

// File: rtl/vid2axis_pkg.sv
package vid2axis_pkg;

  typedef struct packed {
    logic field;
    logic sof;
    logic eol;
  } beat_tag_t;

  localparam int TAG_W = $bits(beat_tag_t);

  // A pixel counts only when qualified, outside both syncs, and after the
  // first frame start has been seen.
  function automatic logic pixel_accepted(input logic de, input logic hs,
                                          input logic vs, input logic armed);
    return de & ~hs & ~vs & armed;
  endfunction

  // Start-of-frame marker waits for the first accepted pixel after a vsync.
  function automatic logic next_sof_pending(input logic pend, input logic vs,
                                            input logic acc);
    if (vs) return 1'b1;
    if (acc) return 1'b0;
    return pend;
  endfunction

endpackage

// File: rtl/vid2axis_capture.sv
module vid2axis_capture
  import vid2axis_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] vid_data,
  input  logic              vid_vsync,
  input  logic              vid_hsync,
  input  logic              vid_de,
  input  logic              vid_field,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data,
  output beat_tag_t         wr_tag,
  output logic              armed
);

  logic              armed_q;
  logic              sof_pend_q;
  logic              stg_valid_q;
  logic [DATA_W-1:0] stg_data_q;
  logic              stg_sof_q;
  logic              stg_field_q;
  logic              accept;

  assign accept = pixel_accepted(vid_de, vid_hsync, vid_vsync, armed_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q     <= 1'b0;
      sof_pend_q  <= 1'b0;
      stg_valid_q <= 1'b0;
      stg_data_q  <= '0;
      stg_sof_q   <= 1'b0;
      stg_field_q <= 1'b0;
    end else begin
      armed_q     <= armed_q | vid_vsync;
      sof_pend_q  <= next_sof_pending(sof_pend_q, vid_vsync, accept);
      stg_valid_q <= accept;
      if (accept) begin
        stg_data_q  <= vid_data;
        stg_sof_q   <= sof_pend_q;
        stg_field_q <= vid_field;
      end
    end
  end

  // The staged pixel is released one cycle later; if no pixel follows it,
  // it closed the line.
  assign wr_en   = stg_valid_q;
  assign wr_data = stg_data_q;
  assign wr_tag  = '{field: stg_field_q, sof: stg_sof_q, eol: ~accept};
  assign armed   = armed_q;

endmodule

// File: rtl/vid2axis_fifo.sv
module vid2axis_fifo #(
  parameter int WIDTH = 11,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_req,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             not_empty,
  output logic             drop
);

  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0]  FULL_CNT  = CNT_W'(DEPTH);

  logic [WIDTH-1:0]  mem [DEPTH];
  logic [ADDR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0]  count_q;
  logic              full, push_ok;

  function automatic logic [ADDR_W-1:0] ptr_step(input logic [ADDR_W-1:0] p);
    return (p == LAST_ADDR) ? '0 : p + 1'b1;
  endfunction

  assign full      = (count_q == FULL_CNT);
  assign push_ok   = push_req & ~full;
  assign drop      = push_req & full;
  assign not_empty = (count_q != '0);
  assign dout      = mem[rd_ptr_q];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (push_ok) wr_ptr_q <= ptr_step(wr_ptr_q);
      if (pop)     rd_ptr_q <= ptr_step(rd_ptr_q);
      count_q <= count_q + CNT_W'(push_ok) - CNT_W'(pop);
    end
  end

endmodule

// File: rtl/vid2axis_bridge.sv
module vid2axis_bridge
  import vid2axis_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] vid_data,
  input  logic              vid_vsync,
  input  logic              vid_hsync,
  input  logic              vid_de,
  input  logic              vid_field,
  output logic [DATA_W-1:0] m_tdata,
  output logic              m_tvalid,
  input  logic              m_tready,
  output logic              m_tuser,
  output logic              m_tlast,
  output logic              m_field,
  output logic              ovf_flag
);

  localparam int ENTRY_W = DATA_W + TAG_W;

  logic              cap_wr;
  logic              cap_armed;
  logic [DATA_W-1:0] cap_data;
  beat_tag_t         cap_tag;
  logic [ENTRY_W-1:0] fifo_dout;
  logic              fifo_drop;
  logic              fifo_pop;
  beat_tag_t         out_tag;
  logic              ovf_q;

  vid2axis_capture #(.DATA_W(DATA_W)) u_capture (
    .clk       (clk),
    .rst_n     (rst_n),
    .vid_data  (vid_data),
    .vid_vsync (vid_vsync),
    .vid_hsync (vid_hsync),
    .vid_de    (vid_de),
    .vid_field (vid_field),
    .wr_en     (cap_wr),
    .wr_data   (cap_data),
    .wr_tag    (cap_tag),
    .armed     (cap_armed)
  );

  vid2axis_fifo #(.WIDTH(ENTRY_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_req  (cap_wr),
    .din       ({cap_tag, cap_data}),
    .pop       (fifo_pop),
    .dout      (fifo_dout),
    .not_empty (m_tvalid),
    .drop      (fifo_drop)
  );

  assign fifo_pop = m_tvalid & m_tready;
  assign out_tag  = beat_tag_t'(fifo_dout[ENTRY_W-1:DATA_W]);
  assign m_tdata  = fifo_dout[DATA_W-1:0];
  assign m_tuser  = out_tag.sof;
  assign m_tlast  = out_tag.eol;
  assign m_field  = out_tag.field;

  always_ff @(posedge clk) begin
    if (!rst_n) ovf_q <= 1'b0;
    else if (fifo_drop) ovf_q <= 1'b1;
  end

  assign ovf_flag = ovf_q;

endmodule

// File: rtl/vid2axis_checker.sv
module vid2axis_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              m_tvalid,
  input logic              m_tready,
  input logic [DATA_W-1:0] m_tdata,
  input logic              m_tuser,
  input logic              m_tlast,
  input logic              m_field,
  input logic              ovf_flag,
  input logic              cap_armed,
  input logic              cap_wr,
  input logic              fifo_drop
);

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (!m_tvalid && !ovf_flag));

  assert_no_write_unarmed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_armed |-> !cap_wr);

  assert_stall_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tuser)
                                 && $stable(m_tlast) && $stable(m_field)));

  assert_drop_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_drop |=> ovf_flag);

  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag |=> ovf_flag);

endmodule

bind vid2axis_bridge vid2axis_checker #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .m_tvalid  (m_tvalid),
  .m_tready  (m_tready),
  .m_tdata   (m_tdata),
  .m_tuser   (m_tuser),
  .m_tlast   (m_tlast),
  .m_field   (m_field),
  .ovf_flag  (ovf_flag),
  .cap_armed (cap_armed),
  .cap_wr    (cap_wr),
  .fifo_drop (fifo_drop)
);

// File: tb/vid2axis_bridge_test.sv
module vid2axis_bridge_test;

  localparam int DW    = 8;
  localparam int DEPTH = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] vid_data = '0;
  logic          vid_vsync = 1'b0, vid_hsync = 1'b0, vid_de = 1'b0, vid_field = 1'b0;
  logic [DW-1:0] m_tdata;
  logic          m_tvalid, m_tuser, m_tlast, m_field, ovf_flag;
  logic          m_tready = 1'b0;

  always #2.5 clk = ~clk;

  vid2axis_bridge #(.DATA_W(DW), .FIFO_DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .vid_data(vid_data), .vid_vsync(vid_vsync),
    .vid_hsync(vid_hsync), .vid_de(vid_de), .vid_field(vid_field),
    .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tready(m_tready),
    .m_tuser(m_tuser), .m_tlast(m_tlast), .m_field(m_field), .ovf_flag(ovf_flag)
  );

  typedef struct {
    logic [DW-1:0] d;
    logic s;
    logic e;
    logic f;
  } exp_t;

  exp_t q[$];
  int compared = 0, mismatched = 0;
  int ready_mode = 0;
  int cyc = 0;
  logic m_armed = 1'b0, m_pend = 1'b0, m_prev_acc = 1'b0;
  logic [DW-1:0] pix = '0;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // consumer ready pattern: 0 always, 1 three of four cycles, 2 never
  always @(posedge clk) begin
    #1;
    cyc++;
    case (ready_mode)
      0: m_tready = 1'b1;
      1: m_tready = (cyc % 4) != 3;
      default: m_tready = 1'b0;
    endcase
  end

  // one native cycle plus the requirement-level model of what it produces
  task automatic drive(input logic de, input logic h, input logic v,
                       input logic [DW-1:0] d, input logic f);
    bit acc;
    exp_t e;
    @(posedge clk); #1;
    vid_de = de; vid_hsync = h; vid_vsync = v; vid_data = d; vid_field = f;
    acc = de && !h && !v && m_armed;              // R2 R9
    if (!acc && m_prev_acc && q.size() > 0) q[q.size()-1].e = 1'b1;   // R4
    if (acc) begin
      e.d = d; e.s = m_pend; e.e = 1'b0; e.f = f;
      q.push_back(e);
    end
    if (v) m_pend = 1'b1; else if (acc) m_pend = 1'b0;   // R3
    if (v) m_armed = 1'b1;
    m_prev_acc = acc;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 1'b0, 1'b0, '0, 1'b0);
  endtask

  task automatic vsync_pulse();
    drive(1'b0, 1'b0, 1'b1, '0, 1'b0);
    drive(1'b0, 1'b0, 1'b1, '0, 1'b0);
    idle(2);
  endtask

  task automatic send_line(input int n, input logic f);
    drive(1'b0, 1'b1, 1'b0, '0, f);
    idle(2);
    for (int i = 0; i < n; i++) begin
      drive(1'b1, 1'b0, 1'b0, pix, f);
      pix = pix + 1'b1;
    end
    idle(3);
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst_n = 1'b0;
    vid_de = 0; vid_hsync = 0; vid_vsync = 0;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    m_armed = 0; m_pend = 0; m_prev_acc = 0;
    q.delete();
  endtask

  // scoreboard on every handshake
  always @(negedge clk) begin
    if (rst_n && m_tvalid && m_tready) begin
      if (q.size() == 0) begin
        check(1'b0, "R2 R8 unexpected beat", int'(m_tdata), -1);
      end else begin
        check(m_tdata == q[0].d, "R6 data order", int'(m_tdata), int'(q[0].d));
        check(m_tuser == q[0].s, "R3 start of frame", int'(m_tuser), int'(q[0].s));
        check(m_tlast == q[0].e, "R4 end of line", int'(m_tlast), int'(q[0].e));
        check(m_field == q[0].f, "R5 field bit", int'(m_field), int'(q[0].f));
        void'(q.pop_front());
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(!m_tvalid, "R1 tvalid in reset", int'(m_tvalid), 0);
    check(!ovf_flag, "R1 ovf in reset", int'(ovf_flag), 0);
    do_reset();
    @(negedge clk);
    check(!m_tvalid, "R1 tvalid after reset", int'(m_tvalid), 0);

    // R2 pixels before any vsync are ignored
    ready_mode = 0;
    send_line(5, 1'b0);
    idle(8);
    @(negedge clk);
    check(!m_tvalid, "R2 no output before vsync", int'(m_tvalid), 0);
    check(q.size() == 0, "R2 model empty", q.size(), 0);

    // R3 R4 R5 R6 frames with both field values, free-flowing consumer
    for (int fr = 0; fr < 2; fr++) begin
      vsync_pulse();
      for (int ln = 0; ln < 3; ln++) send_line(5, logic'(fr));
    end
    idle(10);
    // throttled consumer
    ready_mode = 1;
    for (int fr = 0; fr < 2; fr++) begin
      vsync_pulse();
      for (int ln = 0; ln < 4; ln++) send_line(6, logic'(fr));
    end
    idle(20);
    check(q.size() == 0, "R6 all beats delivered", q.size(), 0);

    // R9 data-valid overlapping hsync and vsync
    ready_mode = 0;
    vsync_pulse();
    drive(1'b1, 1'b0, 1'b1, 8'hE0, 1'b0);
    drive(1'b1, 1'b1, 1'b0, 8'hE1, 1'b0);
    for (int i = 0; i < 3; i++) drive(1'b1, 1'b0, 1'b0, 8'h30 + 8'(i), 1'b1);
    drive(1'b1, 1'b1, 1'b0, 8'hE2, 1'b1);
    for (int i = 0; i < 2; i++) drive(1'b1, 1'b0, 1'b0, 8'h40 + 8'(i), 1'b0);
    idle(10);
    check(q.size() == 0, "R9 sync-masked beats", q.size(), 0);

    // R10 latency into an empty FIFO
    drive(1'b1, 1'b0, 1'b0, 8'h55, 1'b1);
    drive(1'b0, 1'b0, 1'b0, '0, 1'b0);
    @(negedge clk);
    check(!m_tvalid, "R10 not yet after one edge", int'(m_tvalid), 0);
    @(negedge clk);
    check(m_tvalid, "R10 valid after two edges", int'(m_tvalid), 1);
    idle(4);

    // R7 overflow with a stalled consumer
    ready_mode = 2;
    vsync_pulse();
    send_line(DEPTH + 4, 1'b0);
    idle(3);
    @(negedge clk);
    check(ovf_flag, "R7 overflow flagged", int'(ovf_flag), 1);
    while (q.size() > DEPTH) void'(q.pop_back());
    ready_mode = 0;
    idle(20);
    @(negedge clk);
    check(q.size() == 0, "R7 first DEPTH pixels kept", q.size(), 0);
    check(ovf_flag, "R7 overflow sticky", int'(ovf_flag), 1);

    // R8 reset flushes buffered pixels and disarms
    ready_mode = 2;
    vsync_pulse();
    send_line(4, 1'b1);
    @(negedge clk);
    check(m_tvalid, "R8 data buffered before reset", int'(m_tvalid), 1);
    do_reset();
    @(negedge clk);
    check(!m_tvalid, "R8 FIFO empty after reset", int'(m_tvalid), 0);
    check(!ovf_flag, "R1 ovf cleared by reset", int'(ovf_flag), 0);
    ready_mode = 0;
    send_line(4, 1'b0);
    idle(10);
    @(negedge clk);
    check(!m_tvalid, "R8 disarmed until vsync", int'(m_tvalid), 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule